// File: doc/BRIEF.md
# Concurrent Serial Pattern Detectors

This unit samples a single serial data line on every rising clock edge and watches it for three matches at once. Two detectors respond in the same cycle as the last bit of their pattern: one for the four-bit pattern 1011 and one for the three-bit pattern 110. They share the data line but keep separate state, so both can be partly matched at the same moment. Bits from one occurrence may also start the next occurrence.

A third detector also looks for 1011, but its output is registered. It is high for the cycle after the clock edge that takes in the last 1. This detector has its own synchronous clear input. A clear discards everything it has seen, so a complete new 1011 must arrive before its output can rise again. The clear does not affect the other two detectors.

The bit order is the time order: the oldest bit is the leftmost character of each pattern.

Top module: `serial_pattern_watch`

## Requirements
- R1: A synchronous active-low reset (`rst_n` = 0 at a rising edge) returns every detector to its empty state. While reset is held, and in the cycle after it is released, all three outputs are 0.
- R2: `hit_quad` is 1, within the same cycle, exactly when `din` is 1 and the three bits sampled before it, oldest first, were 1, 0, 1. All four bits must have been sampled since the last reset.
- R3: `hit_tri` is 1, within the same cycle, exactly when `din` is 0 and the two bits sampled before it were 1, 1. All three bits must have been sampled since the last reset.
- R4: The two same-cycle detectors track their patterns independently and never assert together, because 1011 ends in 1 and 110 ends in 0. The stream 110110 gives `hit_tri` at the third and sixth bits and `hit_quad` at the fifth bit.
- R5: The same-cycle detectors accept overlapping occurrences. The stream 1011011 raises `hit_quad` twice.
- R6: `hit_reg` is 1 for the cycle after the rising edge that samples the final 1 of a 1011. That 1011 must be formed from bits sampled since the last clear or reset.
- R7: When `clr` is 1 at a rising edge, the registered detector returns to empty. `hit_reg` is 0 in the next cycle, and a complete new 1011 is needed before it rises again. `hit_quad` and `hit_tri` are not affected by `clr`.
- R8: When `clr` is 1, the bit on `din` at that edge is discarded by the registered detector, even if it would have completed 1011.
- R9: Without a clear, the registered detector accepts overlapping occurrences. The stream 1011011 gives two `hit_reg` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 1 | Serial data bit |
| clr | input | 1 | Synchronous clear for the registered 1011 detector |
| hit_quad | output | 1 | Same-cycle flag for 1011 |
| hit_tri | output | 1 | Same-cycle flag for 110 |
| hit_reg | output | 1 | Registered flag for 1011 |

## Verification
The bench feeds every 8-bit word serially, then a long pseudo-random stream with clears scattered through it. It compares all three outputs in every cycle against suffix-match models written arithmetically.

Several mistakes would show up against these models:
- A detector that restarted after each match would miss the second hit in 1011011.
- A clear that leaked into the same-cycle detectors would drop `hit_quad` on a cleared completing bit.
- A clear with lower priority than data would raise `hit_reg` one cycle after a cleared final 1.
- A history not emptied at reset would flag a match from bits sampled before reset.

// File: rtl/spw_pkg.sv
// Shared types for the serial pattern watch block.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package spw_pkg;

    // States of the registered 1011 detector, named after the longest matched prefix.
    typedef enum logic [2:0] {
        PFX_NONE = 3'd0,
        PFX_1    = 3'd1,
        PFX_10   = 3'd2,
        PFX_101  = 3'd3,
        PFX_1011 = 3'd4
    } quad_pfx_t;

endpackage

// File: rtl/spw_suffix_match.sv
// Same-cycle detector for a fixed bit pattern of PAT_LEN bits.
// It keeps the last PAT_LEN-1 sampled bits and a fill count. It flags when
// those bits, followed by the present input, equal PATTERN. The oldest bit is
// the MSB. Overlapping matches are accepted naturally.
// Assumes: PAT_LEN >= 2; reset is synchronous and active low.
module spw_suffix_match #(
    parameter int unsigned          PAT_LEN = 4,
    parameter logic [PAT_LEN-1:0]   PATTERN = 4'b1011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic match
);
    localparam int unsigned HIST_W = PAT_LEN - 1;
    localparam int unsigned FILL_W = $clog2(PAT_LEN);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(HIST_W);

    logic [HIST_W-1:0] hist_q;
    logic [FILL_W-1:0] fill_q;
    logic [HIST_W:0]   window;

    assign window = {hist_q, bit_in};

    // Shift the new bit into the history; count sampled bits up to full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            fill_q <= '0;
        end else begin
            hist_q <= window[HIST_W-1:0];
            if (fill_q != FILL_FULL)
                fill_q <= fill_q + 1'b1;
        end
    end

    // Flag a match only once enough bits have been sampled since reset.
    always_comb begin
        match = (fill_q == FILL_FULL) && (window == PATTERN);
    end

endmodule

// File: rtl/spw_quad_fsm.sv
// Registered 1011 detector with a synchronous clear.
// The output is high only while the state says a full 1011 has been seen.
// A clear returns to the empty state and discards that cycle's data bit.
// Assumes: reset is synchronous and active low; clear outranks data.
module spw_quad_fsm
    import spw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bit_in,
    output logic hit
);
    quad_pfx_t st_q, st_d;

    // Hold the longest matched prefix; reset and clear both empty it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= PFX_NONE;
        else if (clr)
            st_q <= PFX_NONE;
        else
            st_q <= st_d;
    end

    // Next prefix from the present prefix and the incoming bit.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PFX_NONE: st_d = bit_in ? PFX_1    : PFX_NONE;
            PFX_1:    st_d = bit_in ? PFX_1    : PFX_10;
            PFX_10:   st_d = bit_in ? PFX_101  : PFX_NONE;
            PFX_101:  st_d = bit_in ? PFX_1011 : PFX_10;
            PFX_1011: st_d = bit_in ? PFX_1    : PFX_10;
            default:  st_d = PFX_NONE;
        endcase
    end

    // Moore output: only the full-match state raises it.
    always_comb begin
        hit = (st_q == PFX_1011);
    end

endmodule

// File: rtl/serial_pattern_watch.sv
// Top of the serial pattern watch block. It runs three detectors on one
// serial input: same-cycle 1011, same-cycle 110 and a registered 1011
// detector with its own clear.
// Assumes: one data bit per rising edge; synchronous active-low reset.
module serial_pattern_watch #(
    parameter int unsigned QUAD_LEN = 4,
    parameter logic [QUAD_LEN-1:0] QUAD_PAT = 4'b1011,
    parameter int unsigned TRI_LEN  = 3,
    parameter logic [TRI_LEN-1:0]  TRI_PAT  = 3'b110
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic clr,
    output logic hit_quad,
    output logic hit_tri,
    output logic hit_reg
);

    spw_suffix_match #(.PAT_LEN(QUAD_LEN), .PATTERN(QUAD_PAT)) quad_i (
        .clk(clk), .rst_n(rst_n), .bit_in(din), .match(hit_quad)
    );

    spw_suffix_match #(.PAT_LEN(TRI_LEN), .PATTERN(TRI_PAT)) tri_i (
        .clk(clk), .rst_n(rst_n), .bit_in(din), .match(hit_tri)
    );

    spw_quad_fsm reg_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_in(din), .hit(hit_reg)
    );

endmodule

// File: rtl/spw_checker.sv
// Port-level properties of serial_pattern_watch, attached with bind.
// Assumes: the default patterns 1011 and 110.
module spw_checker (
    input logic clk,
    input logic rst_n,
    input logic din,
    input logic clr,
    input logic hit_quad,
    input logic hit_tri,
    input logic hit_reg
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!hit_quad && !hit_tri && !hit_reg));

    // R2
    quad_ends_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_quad |-> din);

    // R3
    tri_ends_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_tri |-> !din);

    // R4
    never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_quad && hit_tri));

    // R6
    reg_after_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_reg |-> ($past(din) && !$past(clr)));

    // R7
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hit_reg);

endmodule

bind serial_pattern_watch spw_checker chk_i (
    .clk(clk), .rst_n(rst_n), .din(din), .clr(clr),
    .hit_quad(hit_quad), .hit_tri(hit_tri), .hit_reg(hit_reg)
);

// File: tb/serial_pattern_watch_tb_top.sv
// Self-checking bench: suffix-match models compared with the outputs in every cycle.
module serial_pattern_watch_tb_top;
    localparam int PER = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic clr = 1'b0;
    logic hit_quad, hit_tri, hit_reg;

    int n_chk = 0;
    int n_err = 0;
    int cnt_q = 0, cnt_t = 0, cnt_r = 0, cnt_both = 0;

    // Reference state: bits since reset (same-cycle) and since clear (registered).
    logic [3:0] m_hist = '0;
    int         m_cnt  = 0;
    logic [3:0] r_hist = '0;
    int         r_cnt  = 0;

    always #(PER/2) clk = ~clk;

    serial_pattern_watch dut_i (
        .clk(clk), .rst_n(rst_n), .din(din), .clr(clr),
        .hit_quad(hit_quad), .hit_tri(hit_tri), .hit_reg(hit_reg)
    );

    task automatic check(input string req, input string what,
                         input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    // One cycle: drive at the negedge, check before the posedge, update the models.
    task automatic step(input logic d, input logic c);
        logic ea, eb, er;
        din = d;
        clr = c;
        #(PER/4);
        ea = rst_n && (m_cnt >= 3) && ({m_hist[2:0], d} == 4'b1011);
        eb = rst_n && (m_cnt >= 2) && ({m_hist[1:0], d} == 3'b110);
        er = (r_cnt >= 4) && (r_hist == 4'b1011);
        check("R2", "hit_quad", hit_quad, ea);
        check("R3", "hit_tri",  hit_tri,  eb);
        check("R6", "hit_reg",  hit_reg,  er);
        if (hit_quad) cnt_q++;
        if (hit_tri)  cnt_t++;
        if (hit_reg)  cnt_r++;
        if (hit_quad && hit_tri) cnt_both++;
        @(posedge clk);
        if (!rst_n) begin
            m_hist = '0; m_cnt = 0; r_hist = '0; r_cnt = 0;
        end else begin
            m_hist = {m_hist[2:0], d};
            m_cnt  = m_cnt + 1;
            if (c) begin
                r_hist = '0; r_cnt = 0;
            end else begin
                r_hist = {r_hist[2:0], d};
                r_cnt  = r_cnt + 1;
            end
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0);
            // R1: outputs stay low under reset
            check("R1", "hit_quad in reset", hit_quad, 1'b0);
            check("R1", "hit_reg in reset",  hit_reg,  1'b0);
        end
        rst_n = 1'b1;
        cnt_q = 0; cnt_t = 0; cnt_r = 0;
    endtask

    task automatic feed(input logic [15:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) step(bits[i], 1'b0);
    endtask

    initial begin
        #(PER * 100000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        do_reset();
        // R1: first cycle after release
        check("R1", "hit_tri after release", hit_tri, 1'b0);

        // R5: overlapping same-cycle 1011 (R9 checked one cycle later)
        feed(16'b1011011, 7);
        check("R5", "hit_quad count", 1'(cnt_q == 2), 1'b1);
        step(1'b0, 1'b0);
        check("R9", "hit_reg count", 1'(cnt_r == 2), 1'b1);

        // R4: 110110 interleaves both same-cycle detectors
        do_reset();
        feed(16'b110110, 6);
        check("R4", "hit_tri count", 1'(cnt_t == 2), 1'b1);
        check("R4", "hit_quad count", 1'(cnt_q == 1), 1'b1);

        // R8/R7: clear on the completing 1 discards it for hit_reg only
        do_reset();
        feed(16'b101, 3);
        step(1'b1, 1'b1);
        check("R7", "hit_quad unaffected by clr", 1'(cnt_q == 1), 1'b1);
        check("R8", "hit_reg after cleared final bit", hit_reg, 1'b0);
        step(1'b1, 1'b0);
        check("R7", "no hit without fresh 1011", 1'(cnt_r == 0), 1'b1);
        feed(16'b011, 3);
        step(1'b0, 1'b0);
        check("R7", "fresh 1011 after clear", 1'(cnt_r == 1), 1'b1);

        // Sweep: every 8-bit word, serially
        do_reset();
        for (int w = 0; w < 256; w++) feed(16'(w), 8);

        // Pseudo-random stream with scattered clears and one reset mid-stream
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i == 2000) do_reset();
            step(lfsr[0], (lfsr[7:4] == 4'hF));
        end
        check("R4", "never both high", 1'(cnt_both == 0), 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule